// File: doc/BRIEF.md
# Set-Associative Tag Tracker with Accessed-Bit Replacement

This block keeps the tag state of a set-associative cache and decides, for every memory access it accepts, whether the access hits or misses. It stores no data. Each access brings a read/write flag, a 32-bit byte address and a byte size. The block takes the set index and the tag from the address and compares the tag against every way of the selected set in the same cycle. On a miss it installs the new tag. It fills an empty way when the set has one. When the set is full it replaces a victim chosen by a one-bit-per-line recency scheme.

Every line has a valid bit, an accessed bit and a tag. Any touch of a line sets its accessed bit, whether the touch is a hit or a fill. When that would leave every accessed bit in the set at one, the set keeps only the bit of the line just touched and clears the rest. Running totals of hits, misses and evictions are available on output ports. A performance model or a trace harness can compare these totals against an expected result.

Top module: `tag_tracker`

## Requirements
- R1: With BLOCK_BYTES=4 and NUM_SETS=2, address bit 2 selects the set and the tag is the address shifted right by 3. The offset bits and reqSize do not affect the result, so 0x800000 and 0x800003 name the same line (set 0, tag 0x100000), while 0x800004 lies in set 1.
- R2: An access hits when a valid way of its set holds its tag. respHit is then 1, and respWay gives that way's index.
- R3: A miss in a set that still has an invalid way fills the lowest-numbered invalid way. respEvict stays 0.
- R4: A miss in a full set replaces the lowest-numbered way whose accessed bit is 0. respEvict is 1 and respWay gives the replaced way.
- R5: A hit or a fill sets the accessed bit of the way it touches. If every accessed bit of the set would then be 1, all bits except the touched way's are cleared.
- R6: Reads and writes behave the same for hit, miss and replacement, and a write miss allocates a line.
- R7: hitCount or missCount rises by exactly one per accepted access. evictCount rises only when a miss replaces a valid line. All counts hold when no access is accepted.
- R8: Synchronous reset clears every valid bit, every accessed bit, the three counters and respValid.
- R9: reqReady is always 1. An access accepted at a clock edge produces respValid=1, with its result and updated counts, right after that edge. Back-to-back accesses in consecutive cycles each get their own result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reqValid | input | 1 | Access request present |
| reqReady | output | 1 | Tracker can accept an access (always 1) |
| reqWrite | input | 1 | 1 = store, 0 = load |
| reqAddr | input | 32 | Byte address of the access |
| reqSize | input | 8 | Bytes accessed (informational) |
| respValid | output | 1 | Result of the access accepted at the previous edge |
| respHit | output | 1 | Access hit |
| respEvict | output | 1 | Access replaced a valid line |
| respWay | output | 2 | Way hit or filled |
| hitCount | output | 32 | Total hits |
| missCount | output | 32 | Total misses |
| evictCount | output | 32 | Total evictions |

## Verification
The lookup is combinational, and the result register and the counters load at the edge that accepts the access. Every response field and the counter values are therefore due one clock edge after acceptance. Each scenario task drives its request on a falling edge and lets one rising edge pass. It samples the outputs on the following falling edge, where they are stable, and compares them with values worked out by hand from the requirements. The back-to-back task keeps reqValid high for two edges and checks each result in its own cycle. It then checks that respValid drops one edge after the request is withdrawn.

// File: rtl/tag_trk_pkg.sv
package tag_trk_pkg;

  typedef struct packed {
    logic apply;    // an access is accepted this cycle
    logic isHit;    // accepted access hits
    logic doEvict;  // accepted access replaces a valid line
  } ctrlStrobes_t;

endpackage

// File: rtl/tag_ctrl.sv
module tag_ctrl
  import tag_trk_pkg::*;
#(
  parameter int NUM_WAYS = 4,
  parameter int WAY_W    = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                reqFire,
  input  logic [NUM_WAYS-1:0] hitVec,
  input  logic [NUM_WAYS-1:0] validVec,
  input  logic [NUM_WAYS-1:0] accVec,
  output ctrlStrobes_t        strobes,
  output logic [WAY_W-1:0]    wayIdx
);

  logic [WAY_W-1:0] hitIdx, freeIdx, coldIdx;
  logic             anyHit, haveFree, haveCold;

  // Descending scan leaves the lowest qualifying way in each index.
  always_comb begin
    hitIdx   = '0;
    freeIdx  = '0;
    coldIdx  = '0;
    haveFree = 1'b0;
    haveCold = 1'b0;
    for (int w = NUM_WAYS - 1; w >= 0; w--) begin
      if (hitVec[w]) hitIdx = WAY_W'(w);
      if (!validVec[w]) begin
        freeIdx  = WAY_W'(w);
        haveFree = 1'b1;
      end
      if (!accVec[w]) begin
        coldIdx  = WAY_W'(w);
        haveCold = 1'b1;
      end
    end
  end

  assign anyHit = |hitVec;

  always_comb begin
    if (anyHit)        wayIdx = hitIdx;
    else if (haveFree) wayIdx = freeIdx;
    else if (haveCold) wayIdx = coldIdx;
    else               wayIdx = '0;
  end

  always_comb begin
    strobes.apply   = reqFire;
    strobes.isHit   = reqFire && anyHit;
    strobes.doEvict = reqFire && !anyHit && !haveFree;
  end

  AST_HIT_UNIQUE: assert property (@(posedge clk) disable iff (rst)
    reqFire |-> $onehot0(hitVec)); // R2

endmodule

// File: rtl/tag_datapath.sv
module tag_datapath
  import tag_trk_pkg::*;
#(
  parameter int NUM_SETS    = 2,
  parameter int NUM_WAYS    = 4,
  parameter int BLOCK_BYTES = 4,
  parameter int ADDR_W      = 32,
  parameter int CNT_W       = 32,
  parameter int WAY_W       = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  ctrlStrobes_t        strobes,
  input  logic [WAY_W-1:0]    wayIdx,
  output logic [NUM_WAYS-1:0] hitVec,
  output logic [NUM_WAYS-1:0] validVec,
  output logic [NUM_WAYS-1:0] accVec,
  output logic                respValid,
  output logic                respHit,
  output logic                respEvict,
  output logic [WAY_W-1:0]    respWay,
  output logic [CNT_W-1:0]    hitCount,
  output logic [CNT_W-1:0]    missCount,
  output logic [CNT_W-1:0]    evictCount
);

  localparam int OFFSET_W = $clog2(BLOCK_BYTES);
  localparam int SET_BITS = $clog2(NUM_SETS);
  localparam int TAG_W    = ADDR_W - OFFSET_W - SET_BITS;

  logic [NUM_SETS-1:0][NUM_WAYS-1:0] validQ;
  logic [NUM_SETS-1:0][NUM_WAYS-1:0] accQ;
  logic [TAG_W-1:0]                  tagQ [NUM_SETS][NUM_WAYS];

  logic [SET_BITS-1:0] setIdx;
  logic [TAG_W-1:0]    reqTag;
  logic [NUM_WAYS-1:0] wayMask, mergedAcc, nextAcc;
  logic                unusedOffset;

  assign setIdx       = reqAddr[OFFSET_W +: SET_BITS];
  assign reqTag       = reqAddr[ADDR_W-1 -: TAG_W];
  assign unusedOffset = ^reqAddr[OFFSET_W-1:0];

  assign validVec = validQ[setIdx];
  assign accVec   = accQ[setIdx];

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_cmp
    assign hitVec[w] = validQ[setIdx][w] && (tagQ[setIdx][w] == reqTag);
  end

  // Touch the chosen way; fold back to just that way when the set saturates.
  assign wayMask   = NUM_WAYS'(1) << wayIdx;
  assign mergedAcc = accVec | wayMask;
  assign nextAcc   = (&mergedAcc) ? wayMask : mergedAcc;

  always_ff @(posedge clk) begin
    if (rst) begin
      validQ     <= '0;
      accQ       <= '0;
      respValid  <= 1'b0;
      respHit    <= 1'b0;
      respEvict  <= 1'b0;
      respWay    <= '0;
      hitCount   <= '0;
      missCount  <= '0;
      evictCount <= '0;
    end else begin
      respValid <= strobes.apply;
      if (strobes.apply) begin
        validQ[setIdx][wayIdx] <= 1'b1;
        accQ[setIdx]           <= nextAcc;
        respHit                <= strobes.isHit;
        respEvict              <= strobes.doEvict;
        respWay                <= wayIdx;
        if (strobes.isHit) hitCount  <= hitCount + 1'b1;
        else               missCount <= missCount + 1'b1;
        if (strobes.doEvict) evictCount <= evictCount + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst && strobes.apply && !strobes.isHit)
      tagQ[setIdx][wayIdx] <= reqTag;
  end

  if (NUM_WAYS > 1) begin : g_accChk
    for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
      AST_NO_ALL_ACCESSED: assert property (@(posedge clk) disable iff (rst)
        !(&accQ[s])); // R5
    end
  end

  AST_EVICT_ONLY_FULL: assert property (@(posedge clk) disable iff (rst)
    strobes.doEvict |-> (&validVec)); // R4

  AST_EVICT_NOT_HIT: assert property (@(posedge clk) disable iff (rst)
    respEvict |-> !respHit); // R7

  AST_ONE_COUNT_PER_ACCESS: assert property (@(posedge clk) disable iff (rst)
    strobes.apply |=> (hitCount + missCount) == $past(hitCount + missCount) + 1'b1); // R7

  AST_IDLE_COUNTS_STABLE: assert property (@(posedge clk) disable iff (rst)
    !strobes.apply |=> $stable(hitCount) && $stable(missCount) && $stable(evictCount)); // R7

endmodule

// File: rtl/tag_tracker.sv
module tag_tracker
  import tag_trk_pkg::*;
#(
  parameter int NUM_SETS    = 2,
  parameter int NUM_WAYS    = 4,
  parameter int BLOCK_BYTES = 4,
  parameter int CNT_W       = 32,
  parameter int WAY_W       = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reqValid,
  output logic             reqReady,
  input  logic             reqWrite,
  input  logic [31:0]      reqAddr,
  input  logic [7:0]       reqSize,
  output logic             respValid,
  output logic             respHit,
  output logic             respEvict,
  output logic [WAY_W-1:0] respWay,
  output logic [CNT_W-1:0] hitCount,
  output logic [CNT_W-1:0] missCount,
  output logic [CNT_W-1:0] evictCount
);

  ctrlStrobes_t        strobes;
  logic [WAY_W-1:0]    wayIdx;
  logic [NUM_WAYS-1:0] hitVec, validVec, accVec;
  logic                reqFire;
  logic                unusedReq;

  assign reqReady  = 1'b1;
  assign reqFire   = reqValid && reqReady;
  // Loads and stores share one path; size never changes the lookup.
  assign unusedReq = reqWrite ^ (^reqSize);

  tag_ctrl #(
    .NUM_WAYS (NUM_WAYS),
    .WAY_W    (WAY_W)
  ) ctrl_i (
    .clk      (clk),
    .rst      (rst),
    .reqFire  (reqFire),
    .hitVec   (hitVec),
    .validVec (validVec),
    .accVec   (accVec),
    .strobes  (strobes),
    .wayIdx   (wayIdx)
  );

  tag_datapath #(
    .NUM_SETS    (NUM_SETS),
    .NUM_WAYS    (NUM_WAYS),
    .BLOCK_BYTES (BLOCK_BYTES),
    .ADDR_W      (32),
    .CNT_W       (CNT_W),
    .WAY_W       (WAY_W)
  ) dp_i (
    .clk        (clk),
    .rst        (rst),
    .reqAddr    (reqAddr),
    .strobes    (strobes),
    .wayIdx     (wayIdx),
    .hitVec     (hitVec),
    .validVec   (validVec),
    .accVec     (accVec),
    .respValid  (respValid),
    .respHit    (respHit),
    .respEvict  (respEvict),
    .respWay    (respWay),
    .hitCount   (hitCount),
    .missCount  (missCount),
    .evictCount (evictCount)
  );

  AST_READY_HIGH: assert property (@(posedge clk) disable iff (rst)
    reqReady); // R9

endmodule

// File: tb/tag_tracker_tb.sv
`timescale 1ns/1ps
module tag_tracker_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic        reqWrite = 1'b0;
  logic [31:0] reqAddr = '0;
  logic [7:0]  reqSize = 8'd4;
  logic        respValid, respHit, respEvict;
  logic [1:0]  respWay;
  logic [31:0] hitCount, missCount, evictCount;

  int testsRun = 0;
  int testsFailed = 0;
  int expHits = 0;
  int expMisses = 0;
  int expEvicts = 0;

  always #10 clk = ~clk;

  tag_tracker dut_i (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqSize(reqSize),
    .respValid(respValid), .respHit(respHit), .respEvict(respEvict),
    .respWay(respWay), .hitCount(hitCount), .missCount(missCount),
    .evictCount(evictCount)
  );

  task automatic check(input string req, input string what,
                       input longint act, input longint exp);
    testsRun++;
    if (act != exp) begin
      testsFailed++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mkAddr(input int tag, input int set);
    return (32'(tag) << 3) | (32'(set) << 2);
  endfunction

  task automatic checkCounts(input string req);
    check(req, "hitCount", hitCount, expHits);
    check(req, "missCount", missCount, expMisses);
    check(req, "evictCount", evictCount, expEvicts);
  endtask

  task automatic checkResp(input string req, input logic expHit,
                           input logic expEvict, input int expWay);
    if (expHit) expHits++; else expMisses++;
    if (expEvict) expEvicts++;
    check(req, "respValid", respValid, 1);
    check(req, "respHit", respHit, expHit);
    check(req, "respEvict", respEvict, expEvict);
    check(req, "respWay", respWay, expWay);
    checkCounts(req);
  endtask

  // Drive at a falling edge, one rising edge accepts, sample at next falling edge.
  task automatic access(input string req, input logic wr, input logic [31:0] addr,
                        input logic [7:0] size, input logic expHit,
                        input logic expEvict, input int expWay);
    reqValid = 1'b1;
    reqWrite = wr;
    reqAddr  = addr;
    reqSize  = size;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    checkResp(req, expHit, expEvict, expWay);
  endtask

  task automatic tReset();
    @(negedge clk);
    check("R8", "respValid after reset", respValid, 0);
    check("R9", "reqReady", reqReady, 1);
    checkCounts("R8");
  endtask

  task automatic tSplit();
    access("R1", 1'b0, 32'h0080_0000, 8'd4, 1'b0, 1'b0, 0);
    access("R1", 1'b0, 32'h0080_0003, 8'd1, 1'b1, 1'b0, 0); // offset ignored, R2 hit
    access("R1", 1'b0, 32'h0080_0004, 8'd4, 1'b0, 1'b0, 0); // set 1 separate
  endtask

  task automatic tFill();
    access("R3", 1'b1, mkAddr(1, 0), 8'd4, 1'b0, 1'b0, 1); // R6 write miss allocates
    access("R3", 1'b1, mkAddr(2, 0), 8'd2, 1'b0, 1'b0, 2);
    access("R3", 1'b1, mkAddr(3, 0), 8'd4, 1'b0, 1'b0, 3); // acc folds to way3 only
  endtask

  task automatic tEvict();
    access("R4", 1'b0, mkAddr(4, 0), 8'd4, 1'b0, 1'b1, 0);
    access("R4", 1'b0, 32'h0080_0000, 8'd4, 1'b0, 1'b1, 1);
    access("R2", 1'b0, mkAddr(3, 0), 8'd4, 1'b1, 1'b0, 3);
    access("R5", 1'b0, mkAddr(2, 0), 8'd4, 1'b1, 1'b0, 2); // saturates: keep way2 only
    access("R5", 1'b0, mkAddr(4, 0), 8'd4, 1'b1, 1'b0, 0);
    access("R5", 1'b0, mkAddr(5, 0), 8'd4, 1'b0, 1'b1, 1); // way1 cold after clear
    access("R5", 1'b0, mkAddr(6, 0), 8'd4, 1'b0, 1'b1, 3);
  endtask

  task automatic tWriteHit();
    access("R6", 1'b1, mkAddr(5, 0), 8'd4, 1'b1, 1'b0, 1);
    repeat (2) @(negedge clk);
    check("R7", "respValid idle", respValid, 0);
    checkCounts("R7");
  endtask

  task automatic tBackToBack();
    reqValid = 1'b1;
    reqWrite = 1'b0;
    reqAddr  = 32'h0080_0004;
    @(posedge clk);
    @(negedge clk);
    reqAddr = mkAddr(7, 1);
    checkResp("R9", 1'b1, 1'b0, 0);
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    checkResp("R9", 1'b0, 1'b0, 1);
    @(posedge clk);
    @(negedge clk);
    check("R9", "respValid drops", respValid, 0);
  endtask

  task automatic tResetClears();
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    expHits = 0; expMisses = 0; expEvicts = 0;
    check("R8", "respValid", respValid, 0);
    checkCounts("R8");
    access("R8", 1'b0, 32'h0080_0000, 8'd4, 1'b0, 1'b0, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    tReset();
    tSplit();
    tFill();
    tEvict();
    tWriteHit();
    tBackToBack();
    tResetClears();
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    testsRun++;
    testsFailed++;
    $display("FAIL R9 watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule